// File: doc/BRIEF.md
# Byte-Wide SPI Host Controller

This block is a memory-mapped SPI host with seven byte-wide registers behind a simple one-cycle register port. Software selects the serial clock rate with a 4-bit divider code, which is split between two registers. It also picks the clock polarity and phase, and drives four chip-select lines directly from one register. Each line has its own override enable and its own output level.

Writing a byte to the data register starts one 8-bit full-duplex exchange, most significant bit first. The byte shifted in from `miso` goes into a four-entry receive FIFO, and each read of the data register takes the oldest entry from it. Status flags report the following:
- the FIFO is empty;
- an exchange has completed;
- a data write arrived while the shifter was busy.

Register reads are registered, so `rdata` is valid in the cycle after `rd_en`.

Top module: `spi_byte_host`

## Requirements
- R1: After reset every register reads 0, except status, which reads 0x01 (FIFO empty). `sclk` is 0 and every chip-select output is 1.
- R2: The offsets are: control 0, status 1, data 2, divider-extension 3, parameter 4, chip-select 5, timing 6. In control, bit 2 is phase, bit 3 is polarity and bit 6 is enable. Only bit 0 of parameter is stored; its other bits read 0. Control, divider-extension, chip-select and timing store the whole byte. Read data appears on `rdata` one cycle after `rd_en`.
- R3: The divider code is {extension[1:0], control[1:0]}. One `sclk` period lasts this many system clocks for codes 0..11: 2, 4, 16, 32, 8, 64, 128, 256, 512, 1024, 2048, 4096. Codes 12..15 use 4096. Each half of the period is half that count.
- R4: A data write while enabled and idle starts an exchange of 8 bits, most significant first. At the end, the received byte is pushed into the FIFO and status bit 7 (complete) is set.
- R5: Between exchanges `sclk` rests at the polarity bit. With phase 0, both sides sample on the leading edge and change data on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: A data write during an exchange sets status bit 6 (collision). The written byte is discarded and the running exchange finishes unaltered.
- R7: Writing 1 to status bit 6 or bit 7 clears that flag. Writing 0 leaves it as it was.
- R8: The FIFO holds 4 bytes and status bit 0 is 1 while it is empty. A data read returns and removes the oldest byte. A push into a full FIFO discards the oldest byte.
- R9: Chip-select line n is driven to chip-select register bit n when bit 4+n is set. Otherwise it is driven high.
- R10: While enable is 0, `sclk` stays at the polarity level and data writes are ignored: no exchange, no flag, no FIFO change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_o | output | 4 | Chip-select lines |

## Verification
The bench builds the block with its default parameters: 8-bit words, a four-entry FIFO and a 12-bit divider counter. This lets it reach the largest divide ratio and the clamped codes 12..15 within the run, at 16 × 2048 cycles per exchange. The FIFO is shallow enough that five back-to-back exchanges overflow it, which exposes the discard-oldest rule. The bench runs the four clock modes against a bench-side serial peer. It measures the half-period from `sclk` edges for codes whose ratios are out of order, so that a monotonic decode is caught.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;

    localparam int DATA_W = 8;
    localparam int NUM_SEL = 4;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_DATA  = 3'd2,
        A_EXT   = 3'd3,
        A_PARAM = 3'd4,
        A_SEL   = 3'd5,
        A_TIME  = 3'd6
    } reg_addr_e;

    localparam int B_PHASE  = 2;
    localparam int B_POL    = 3;
    localparam int B_ENABLE = 6;
    localparam int B_EMPTY  = 0;
    localparam int B_COLL   = 6;
    localparam int B_DONE   = 7;

    typedef struct packed {
        logic       en;
        logic       pol;
        logic       phase;
        logic [3:0] code;
    } link_cfg_t;

    // log2 of the sclk period in system clocks for a divider code
    function automatic logic [3:0] period_log2(input logic [3:0] code);
        case (code)
            4'd0:    period_log2 = 4'd1;
            4'd1:    period_log2 = 4'd2;
            4'd2:    period_log2 = 4'd4;
            4'd3:    period_log2 = 4'd5;
            4'd4:    period_log2 = 4'd3;
            4'd5:    period_log2 = 4'd6;
            4'd6:    period_log2 = 4'd7;
            4'd7:    period_log2 = 4'd8;
            4'd8:    period_log2 = 4'd9;
            4'd9:    period_log2 = 4'd10;
            4'd10:   period_log2 = 4'd11;
            default: period_log2 = 4'd12;
        endcase
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick
);
    import spi_host_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic [3:0]       lg;

    always_comb begin
        lg      = period_log2(code);
        half_m1 = (CNT_W'(1) << (lg - 4'd1)) - CNT_W'(1);
    end

    assign tick = run && (cnt == half_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            pol,
    input  logic            phase,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);

    logic [BITS-1:0] tx_sr, rx_sr;
    logic [EW-1:0]   edge_idx;
    logic            lead, samp, shft;

    always_comb begin
        lead = (edge_idx[0] == 1'b0);
        samp = phase ? !lead : lead;
        shft = phase ? (lead && edge_idx != '0) : !lead;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            sclk     <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            edge_idx <= '0;
            done     <= 1'b0;
        end else if (!en) begin
            busy <= 1'b0;
            sclk <= pol;
            done <= 1'b0;
        end else if (!busy) begin
            sclk <= pol;
            done <= 1'b0;
            if (start) begin
                busy     <= 1'b1;
                tx_sr    <= tx_byte;
                edge_idx <= '0;
            end
        end else begin
            done <= 1'b0;
            if (tick) begin
                sclk <= ~sclk;
                if (samp) rx_sr <= {rx_sr[BITS-2:0], miso};
                if (shft) tx_sr <= {tx_sr[BITS-2:0], 1'b0};
                edge_idx <= edge_idx + EW'(1);
                if (edge_idx == EW'(EDGES - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign mosi    = tx_sr[BITS-1];
    assign rx_byte = rx_sr;
endmodule

// File: rtl/spi_rx_fifo.sv
`timescale 1ns/1ps
module spi_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_pop, drop;

    always_comb begin
        empty  = (count == '0);
        full   = (count == (AW+1)'(DEPTH));
        do_pop = pop && !empty;
        drop   = push && full && !do_pop;
    end

    assign dout = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= wp + AW'(1);
            end
            if (do_pop || drop) rp <= rp + AW'(1);
            if (push && !do_pop && !full) count <= count + (AW+1)'(1);
            else if (do_pop && !push)     count <= count - (AW+1)'(1);
        end
    end
endmodule

// File: rtl/spi_byte_host.sv
`timescale 1ns/1ps
module spi_byte_host #(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic [3:0] sel_o
);
    import spi_host_pkg::*;

    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [7:0] ctrl_q, ext_q, sel_q, time_q;
    logic       param_q, done_flag, coll_flag;
    link_cfg_t  cfg;

    logic       eng_busy, eng_done, tick, start, data_wr, data_rd;
    logic [7:0] rx_byte, fifo_dout;
    logic       fifo_empty;
    logic [CW-1:0] fifo_count;

    always_comb begin
        cfg.en    = ctrl_q[B_ENABLE];
        cfg.pol   = ctrl_q[B_POL];
        cfg.phase = ctrl_q[B_PHASE];
        cfg.code  = {ext_q[1:0], ctrl_q[1:0]};
        data_wr   = wr_en && (addr == A_DATA);
        data_rd   = rd_en && (addr == A_DATA);
        start     = data_wr && cfg.en && !eng_busy;
    end

    spi_clk_div #(.CNT_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(eng_busy), .code(cfg.code), .tick(tick)
    );

    spi_shifter #(.BITS(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .en(cfg.en), .pol(cfg.pol), .phase(cfg.phase),
        .start(start), .tx_byte(wdata), .tick(tick), .miso(miso),
        .busy(eng_busy), .sclk(sclk), .mosi(mosi), .done(eng_done),
        .rx_byte(rx_byte)
    );

    spi_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst(rst), .push(eng_done), .pop(data_rd), .din(rx_byte),
        .dout(fifo_dout), .empty(fifo_empty), .count(fifo_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            ext_q     <= '0;
            sel_q     <= '0;
            time_q    <= '0;
            param_q   <= 1'b0;
            done_flag <= 1'b0;
            coll_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL:  ctrl_q  <= wdata;
                    A_EXT:   ext_q   <= wdata;
                    A_PARAM: param_q <= wdata[0];
                    A_SEL:   sel_q   <= wdata;
                    A_TIME:  time_q  <= wdata;
                    A_STAT: begin
                        if (wdata[B_DONE]) done_flag <= 1'b0;
                        if (wdata[B_COLL]) coll_flag <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (eng_done) done_flag <= 1'b1;
            if (data_wr && cfg.en && eng_busy) coll_flag <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd_en) begin
            case (addr)
                A_CTRL:  rdata <= ctrl_q;
                A_STAT:  rdata <= {done_flag, coll_flag, 5'b0, fifo_empty};
                A_DATA:  rdata <= fifo_dout;
                A_EXT:   rdata <= ext_q;
                A_PARAM: rdata <= {7'b0, param_q};
                A_SEL:   rdata <= sel_q;
                A_TIME:  rdata <= time_q;
                default: rdata <= '0;
            endcase
        end
    end

    for (genvar n = 0; n < NUM_SEL; n++) begin : g_sel
        assign sel_o[n] = sel_q[NUM_SEL + n] ? sel_q[n] : 1'b1;
    end
endmodule

// File: rtl/spi_byte_host_chk.sv
`timescale 1ns/1ps
module spi_byte_host_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          sclk,
    input logic          pol,
    input logic          en,
    input logic          busy,
    input logic          data_wr,
    input logic          coll,
    input logic          done,
    input logic          done_flag,
    input logic          push,
    input logic [CW-1:0] count
);
    p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $stable(pol)) |-> (sclk == pol));

    p_collision_r6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && busy && en) |=> coll);

    p_done_flag_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> done_flag);

    p_fifo_bound_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(FIFO_DEPTH));

    p_push_fills_r8: assert property (@(posedge clk) disable iff (rst)
        push |=> (count != '0));

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> !busy);
endmodule

bind spi_byte_host spi_byte_host_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .sclk(sclk), .pol(cfg.pol), .en(cfg.en),
    .busy(eng_busy), .data_wr(data_wr), .coll(coll_flag), .done(eng_done),
    .done_flag(done_flag), .push(eng_done), .count(fifo_count)
);

// File: tb/spi_byte_host_bench.sv
`timescale 1ns/1ps
module spi_byte_host_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic sclk, mosi, miso = 1'b0;
    logic [3:0] sel_o;

    spi_byte_host u_spi_byte_host (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
        .sel_o(sel_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;

    // serial peer
    bit   slave_act = 0, b_pol = 0, b_phase = 0;
    logic [7:0] s_sh, s_rx;
    int   e_cnt, c1, c2;
    always @(sclk) begin
        if (slave_act) begin
            e_cnt++;
            if (e_cnt == 1) c1 = cyc;
            if (e_cnt == 2) c2 = cyc;
            if (sclk != b_pol) begin
                if (!b_phase) s_rx = {s_rx[6:0], mosi};
                else begin miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
            end else begin
                if (!b_phase) begin miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
                else s_rx = {s_rx[6:0], mosi};
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    function automatic int exp_period(input logic [3:0] c);
        case (c)
            0: return 2;    1: return 4;    2: return 16;   3: return 32;
            4: return 8;    5: return 64;   6: return 128;  7: return 256;
            8: return 512;  9: return 1024; 10: return 2048;
            default: return 4096;
        endcase
    endfunction

    task automatic wait_done();
        logic [7:0] st;
        for (int i = 0; i < 40000; i++) begin
            rd(3'd1, st);
            if (st[7]) break;
        end
    endtask

    task automatic setup_mode(input logic [1:0] mode, input logic [3:0] code);
        b_pol = mode[1]; b_phase = mode[0];
        wr(3'd0, 8'h40 | (8'(mode[1]) << 3) | (8'(mode[0]) << 2) | 8'(code[1:0]));
        wr(3'd3, 8'(code[3:2]));
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] sl);
        s_rx = '0; e_cnt = 0;
        if (!b_phase) begin miso = sl[7]; s_sh = {sl[6:0], 1'b0}; end
        else s_sh = sl;
        slave_act = 1;
        wr(3'd2, tx);
        wait_done();
        slave_act = 0;
    endtask

    // {mode[1:0], code[3:0], tx[7:0], peer[7:0]}
    localparam logic [21:0] VEC [6] = '{
        {2'd0, 4'd0,  8'hA5, 8'h3C},
        {2'd1, 4'd1,  8'h81, 8'h7E},
        {2'd2, 4'd4,  8'h5A, 8'hC3},
        {2'd3, 4'd2,  8'hF0, 8'h0F},
        {2'd0, 4'd3,  8'h01, 8'h80},
        {2'd2, 4'd13, 8'h96, 8'h69}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_900_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 sclk", sclk, 0);
        chk("R1 sel_o", sel_o, 4'hF);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk($sformatf("R1 reg %0d", a), d, (a == 1) ? 8'h01 : 8'h00);
        end

        // R2 storage widths
        wr(3'd4, 8'hFF); rd(3'd4, d); chk("R2 param bit only", d, 8'h01);
        wr(3'd6, 8'hA5); rd(3'd6, d); chk("R2 timing byte", d, 8'hA5);
        wr(3'd3, 8'hC2); rd(3'd3, d); chk("R2 ext byte", d, 8'hC2);

        // R9 chip selects
        wr(3'd5, 8'h35); @(negedge clk); chk("R9 partial enable", sel_o, 4'b1101);
        wr(3'd5, 8'hF2); @(negedge clk); chk("R9 all enabled", sel_o, 4'b0010);
        rd(3'd5, d); chk("R9 readback", d, 8'hF2);

        // R10 disabled: no exchange, idle level follows polarity
        wr(3'd0, 8'h08); @(negedge clk); chk("R10 idle high", sclk, 1);
        wr(3'd2, 8'h55); repeat (40) @(negedge clk);
        chk("R10 sclk held", sclk, 1);
        rd(3'd1, d); chk("R10 status untouched", d, 8'h01);

        // R3 R4 R5 table walk
        foreach (VEC[i]) begin
            logic [1:0] m = VEC[i][21:20];
            logic [3:0] c = VEC[i][19:16];
            logic [7:0] tx = VEC[i][15:8];
            logic [7:0] sl = VEC[i][7:0];
            setup_mode(m, c);
            repeat (2) @(negedge clk);
            chk($sformatf("R5 idle level v%0d", i), sclk, m[1]);
            xfer(tx, sl);
            chk($sformatf("R3 half period v%0d", i), c2 - c1, exp_period(c) / 2);
            chk($sformatf("R5 edge count v%0d", i), e_cnt, 16);
            chk($sformatf("R4 peer got v%0d", i), s_rx, tx);
            rd(3'd1, d); chk($sformatf("R4 status v%0d", i), d, 8'h80);
            rd(3'd2, d); chk($sformatf("R4 rx byte v%0d", i), d, sl);
            wr(3'd1, 8'h80);
            rd(3'd1, d); chk($sformatf("R8 empty again v%0d", i), d, 8'h01);
            chk($sformatf("R5 rest level v%0d", i), sclk, m[1]);
        end

        // R6 collision
        setup_mode(2'd0, 4'd1);
        s_rx = '0; e_cnt = 0; miso = 1'b1; s_sh = 8'hCA << 1; slave_act = 1;
        wr(3'd2, 8'h3E);
        wr(3'd2, 8'hFF);
        wait_done(); slave_act = 0;
        chk("R6 first byte kept", s_rx, 8'h3E);
        rd(3'd1, d); chk("R6 collision flag", d, 8'hC0);
        // R7 clear one flag at a time
        wr(3'd1, 8'h40); rd(3'd1, d); chk("R7 clear collision only", d, 8'h80);
        wr(3'd1, 8'h00); rd(3'd1, d); chk("R7 zero write keeps", d, 8'h80);
        rd(3'd2, d); chk("R6 single entry", d, 8'hCA);
        wr(3'd1, 8'h80); rd(3'd1, d); chk("R7 clear done", d, 8'h01);

        // R8 overflow drops oldest
        setup_mode(2'd0, 4'd0);
        for (int k = 0; k < 5; k++) begin
            xfer(8'h00, 8'h10 + 8'(k));
            wr(3'd1, 8'h80);
        end
        for (int k = 1; k < 5; k++) begin
            rd(3'd2, d); chk($sformatf("R8 order %0d", k), d, 8'h10 + k);
        end
        rd(3'd1, d); chk("R8 empty after drain", d, 8'h01);

        // R10 clearing enable aborts and ignores writes
        setup_mode(2'd0, 4'd11);
        wr(3'd2, 8'hAA);
        repeat (20) @(negedge clk);
        wr(3'd0, 8'h00);
        repeat (3) @(negedge clk);
        chk("R10 abort idle", sclk, 0);
        rd(3'd1, d); chk("R10 no completion", d, 8'h01);

        finish_run();
    end
endmodule